// File: doc/BRIEF.md
# Frequency-Compensated Time Counter

This block keeps a 64-bit time count that advances at a programmable nominal rate derived from a faster source clock. On each enabled source-clock edge, a 32-bit addend is summed into a 32-bit phase accumulator. Each carry out of that accumulator advances the count by one. The mean tick rate is therefore the source rate times addend / 2^32. Software can retune the addend while the counter runs, which lets a servo loop trim the frequency without stopping time.

A bypass mode skips the accumulator, so the counter then steps on every enabled edge. A 64-bit offset is added to the raw count to form the reported time. A small word-addressed register bus gives access to control, addend, count, offset and accumulator.

The 64-bit quantities cross the 32-bit bus in two halves:
- **Reads:** reading the low half of the count captures the high half at the same instant.
- **Writes:** writing the low half only stages it. The 64-bit value takes effect when the high half is written.

The block's outputs are the reported time and a one-cycle tick strobe for downstream comparators.

Top module: `ftc_timebase`

## Requirements
- R1: After synchronous reset, the time output, tick, control, addend, count, offset and accumulator are all zero.
- R2: With control bit 0 (enable) set and bit 1 (bypass) clear, each edge adds the addend (word address 1) to the accumulator modulo 2^32. The count advances by one exactly on each carry out. The accumulator reads back at word address 6.
- R3: An addend written while counting applies from the next edge on, with no pause in counting.
- R4: With enable and bypass both set, the count advances by one on every edge and the accumulator holds.
- R5: With enable clear, count and accumulator hold their values.
- R6: While control bit 2 (soft reset) is set, each edge clears count and accumulator, whatever the enable. The offset is kept.
- R7: Reading the count low half (word address 2) captures the high half. A later read of word address 3 returns that captured value, not the live one.
- R8: Writing word address 2 only stages the value, with no visible effect. Writing word address 3 then loads {written word, staged word} into the count on that edge, overriding any increment.
- R9: The offset is written the same way (stage at address 4, commit at address 5) and reads back at 4/5. The time output equals count plus offset, updated on the same edge as both.
- R10: The count wraps from all ones to zero, with no flag.
- R11: Tick is high for exactly the cycles following an edge on which the count incremented.
- R12: A read strobe at one edge yields read data with the read-valid flag high after that edge, and read-valid low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| time_now | output | 64 | Count plus offset |
| tick | output | 1 | One-cycle pulse per count increment |

## Verification
The hardest case to reach from the ports is a read of the high half while the live count has already carried into it since the low-half read. Only then does the captured value differ from the live one. The stimulus loads the count two steps below a low-half rollover, then enables bypass. It reads the low half on the very next edge and lets the counter run across the rollover. It then reads the high half and expects the pre-carry value. Accumulator behaviour is driven with addends whose carry counts are exact fractions of the enabled-edge count, including a mid-run addend change, so expected counts follow from the summed addends.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  typedef enum logic [2:0] {
    ADR_CTRL   = 3'd0,
    ADR_ADDEND = 3'd1,
    ADR_CNT_LO = 3'd2,
    ADR_CNT_HI = 3'd3,
    ADR_OFF_LO = 3'd4,
    ADR_OFF_HI = 3'd5,
    ADR_ACC    = 3'd6
  } reg_addr_e;

  localparam int ADDR_W        = 3;
  localparam int CTRL_W        = 3;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_BYP_BIT  = 1;
  localparam int CTRL_SRST_BIT = 2;
endpackage

// File: rtl/ftc_rate_accum.sv
module ftc_rate_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             bypass,
  input  logic             srst,
  input  logic [ACC_W-1:0] addend,
  output logic             inc,
  output logic [ACC_W-1:0] acc
);
  localparam int SUM_W = ACC_W + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = {1'b0, acc} + {1'b0, addend};
    inc = en && !srst && (bypass || sum[ACC_W]);
  end

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      acc <= '0;
    end else if (en && !bypass) begin
      acc <= sum[ACC_W-1:0];
    end
  end

  // R4: bypass forces a step on every enabled edge
  a_r4_bypass_step: assert property (@(posedge clk) disable iff (rst)
    (en && bypass && !srst) |-> inc);

  // R2: accumulator advances by the addend
  a_r2_acc_add: assert property (@(posedge clk) disable iff (rst)
    (en && !bypass && !srst) |=> acc == ACC_W'($past(acc) + $past(addend)));

  // R5: accumulator holds when disabled
  a_r5_acc_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !srst) |=> $stable(acc));

  // R6: soft reset clears accumulator
  a_r6_acc_clear: assert property (@(posedge clk) disable iff (rst)
    srst |=> acc == '0);
endmodule

// File: rtl/ftc_counter64.sv
module ftc_counter64 #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst,
  input  logic             inc,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_load_val,
  input  logic             off_load,
  input  logic [CNT_W-1:0] off_load_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] off,
  output logic [CNT_W-1:0] time_now,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] off_nxt;
  logic             step;

  always_comb begin
    step = inc && !srst && !cnt_load;
    if (srst)          cnt_nxt = '0;
    else if (cnt_load) cnt_nxt = cnt_load_val;
    else if (step)     cnt_nxt = cnt + CNT_W'(1);
    else               cnt_nxt = cnt;
    off_nxt = off_load ? off_load_val : off;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      off      <= '0;
      time_now <= '0;
      tick     <= 1'b0;
    end else begin
      cnt      <= cnt_nxt;
      off      <= off_nxt;
      time_now <= cnt_nxt + off_nxt;
      tick     <= step;
    end
  end

  // R2: a granted increment moves the count by exactly one (wraps, R10)
  a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
    (inc && !srst && !cnt_load) |=> cnt == $past(cnt) + CNT_W'(1));

  // R5: no increment, no load, no clear -> count holds
  a_r5_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (!inc && !srst && !cnt_load) |=> $stable(cnt));

  // R6: soft reset clears count
  a_r6_cnt_clear: assert property (@(posedge clk) disable iff (rst)
    srst |=> cnt == '0);

  // R11: tick only follows an increment
  a_r11_tick_step: assert property (@(posedge clk) disable iff (rst)
    tick |-> cnt == $past(cnt) + CNT_W'(1));

  // R9: reported time tracks count plus offset
  a_r9_time_sum: assert property (@(posedge clk) disable iff (rst)
    time_now == cnt + off);
endmodule

// File: rtl/ftc_regbank.sv
module ftc_regbank
  import ftc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  input  logic [2*DATA_W-1:0] cnt,
  input  logic [2*DATA_W-1:0] off,
  input  logic [DATA_W-1:0]   acc,
  output logic                en,
  output logic                bypass,
  output logic                srst,
  output logic [DATA_W-1:0]   addend,
  output logic                cnt_load,
  output logic [2*DATA_W-1:0] cnt_load_val,
  output logic                off_load,
  output logic [2*DATA_W-1:0] off_load_val
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic [CTRL_W-1:0] ctrl;
  logic [DATA_W-1:0] cnt_stage;
  logic [DATA_W-1:0] off_stage;
  logic [DATA_W-1:0] snap_hi;

  always_comb begin
    en           = ctrl[CTRL_EN_BIT];
    bypass       = ctrl[CTRL_BYP_BIT];
    srst         = ctrl[CTRL_SRST_BIT];
    cnt_load     = bus_wr && (bus_addr == ADR_CNT_HI);
    cnt_load_val = {bus_wdata, cnt_stage};
    off_load     = bus_wr && (bus_addr == ADR_OFF_HI);
    off_load_val = {bus_wdata, off_stage};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl       <= '0;
      addend     <= '0;
      cnt_stage  <= '0;
      off_stage  <= '0;
      snap_hi    <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_wr) begin
        case (reg_addr_e'(bus_addr))
          ADR_CTRL:   ctrl      <= bus_wdata[CTRL_W-1:0];
          ADR_ADDEND: addend    <= bus_wdata;
          ADR_CNT_LO: cnt_stage <= bus_wdata;
          ADR_OFF_LO: off_stage <= bus_wdata;
          default:    ;
        endcase
      end
      if (bus_rd) begin
        case (reg_addr_e'(bus_addr))
          ADR_CTRL:   bus_rdata <= {{PAD_W{1'b0}}, ctrl};
          ADR_ADDEND: bus_rdata <= addend;
          ADR_CNT_LO: begin
            bus_rdata <= cnt[DATA_W-1:0];
            snap_hi   <= cnt[2*DATA_W-1:DATA_W];
          end
          ADR_CNT_HI: bus_rdata <= snap_hi;
          ADR_OFF_LO: bus_rdata <= off[DATA_W-1:0];
          ADR_OFF_HI: bus_rdata <= off[2*DATA_W-1:DATA_W];
          ADR_ACC:    bus_rdata <= acc;
          default:    bus_rdata <= '0;
        endcase
      end
    end
  end

  // R7: low-half read captures the live high half
  a_r7_snap_capture: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADR_CNT_LO) |=> snap_hi == $past(cnt[2*DATA_W-1:DATA_W]));

  // R7: high-half read returns the captured value
  a_r7_hi_from_snap: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADR_CNT_HI) |=> bus_rdata == $past(snap_hi));

  // R12: read-valid follows the read strobe by one edge
  a_r12_rvalid_set: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  a_r12_rvalid_clr: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
endmodule

// File: rtl/ftc_timebase.sv
module ftc_timebase
  import ftc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  output logic [2*DATA_W-1:0] time_now,
  output logic                tick
);
  localparam int CNT_W = 2 * DATA_W;

  logic             en, bypass, srst, inc;
  logic [DATA_W-1:0] addend, acc;
  logic             cnt_load, off_load;
  logic [CNT_W-1:0] cnt_load_val, off_load_val, cnt, off;

  ftc_regbank #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .cnt(cnt), .off(off), .acc(acc),
    .en(en), .bypass(bypass), .srst(srst), .addend(addend),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .off_load(off_load), .off_load_val(off_load_val)
  );

  ftc_rate_accum #(.ACC_W(DATA_W)) u_accum (
    .clk(clk), .rst(rst), .en(en), .bypass(bypass), .srst(srst),
    .addend(addend), .inc(inc), .acc(acc)
  );

  ftc_counter64 #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .srst(srst), .inc(inc),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .off_load(off_load), .off_load_val(off_load_val),
    .cnt(cnt), .off(off), .time_now(time_now), .tick(tick)
  );
endmodule

// File: tb/ftc_timebase_bench.sv
module ftc_timebase_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [63:0] time_now;
  logic        tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  ftc_timebase u_ftc_timebase (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .time_now(time_now), .tick(tick)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] e, string req);
    exp_q.push_back(e);
    tag_q.push_back(req);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop expected read data as results appear
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R12 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), {32'h0, bus_rdata}, {32'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    // R1 reset state
    chk("R1 time", time_now, 64'h0);
    chk("R1 tick", {63'h0, tick}, 64'h0);
    rd(3'd0, 32'h0, "R1 ctrl");
    rd(3'd1, 32'h0, "R1 addend");
    rd(3'd2, 32'h0, "R1 cnt lo");
    rd(3'd6, 32'h0, "R1 acc");
    idle(1);
    chk("R12 rvalid idle", {63'h0, bus_rvalid}, 64'h0);

    // R4 bypass: 10 enabled edges
    wr(3'd0, 32'h3);
    idle(1);
    chk("R11 tick in bypass", {63'h0, tick}, 64'h1);
    idle(8);
    wr(3'd0, 32'h0);
    idle(1);
    chk("R11 tick drops", {63'h0, tick}, 64'h0);
    chk("R4 time after bypass", time_now, 64'd10);
    rd(3'd2, 32'd10, "R4 cnt lo");
    idle(5);
    rd(3'd2, 32'd10, "R5 held while disabled");
    rd(3'd3, 32'd0, "R4 cnt hi");

    // R6 soft reset with enable set
    wr(3'd0, 32'h5);
    wr(3'd0, 32'h0);
    chk("R6 time cleared", time_now, 64'h0);
    rd(3'd2, 32'h0, "R6 cnt lo");

    // R2 accumulator: 3 edges of 0.75
    wr(3'd1, 32'hC000_0000);
    wr(3'd0, 32'h1);
    idle(2);
    wr(3'd0, 32'h0);
    rd(3'd2, 32'd2, "R2 carries");
    rd(3'd6, 32'h4000_0000, "R2 acc value");
    idle(4);
    rd(3'd6, 32'h4000_0000, "R5 acc held");

    // R3 runtime addend change: 8 edges at 0.25, 8 at 0.5
    wr(3'd0, 32'h4);
    wr(3'd1, 32'h4000_0000);
    wr(3'd0, 32'h1);
    idle(7);
    wr(3'd1, 32'h8000_0000);
    idle(7);
    wr(3'd0, 32'h0);
    rd(3'd2, 32'd6, "R3 carries after trim");
    rd(3'd6, 32'h0, "R3 acc");

    // R8 staged count write
    wr(3'd0, 32'h4);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h1111_1111);
    rd(3'd2, 32'h0, "R8 low write staged only");
    wr(3'd3, 32'h5);
    chk("R8 time after load", time_now, 64'h5_1111_1111);
    rd(3'd2, 32'h1111_1111, "R8 cnt lo");
    rd(3'd3, 32'h5, "R8 cnt hi");

    // R7 snapshot across a low-half rollover
    wr(3'd2, 32'hFFFF_FFFE);
    wr(3'd3, 32'h5);
    wr(3'd0, 32'h3);
    rd(3'd2, 32'hFFFF_FFFE, "R7 lo");
    idle(10);
    rd(3'd3, 32'h5, "R7 hi from snapshot");
    wr(3'd0, 32'h0);
    rd(3'd2, 32'h0000_000B, "R7 live lo");
    rd(3'd3, 32'h6, "R7 live hi");

    // R9 offset
    wr(3'd4, 32'h100);
    chk("R9 offset low staged", time_now, 64'h6_0000_000B);
    wr(3'd5, 32'h2);
    chk("R9 time with offset", time_now, 64'h8_0000_010B);
    rd(3'd4, 32'h100, "R9 off lo");
    rd(3'd5, 32'h2, "R9 off hi");
    wr(3'd0, 32'h3);
    idle(4);
    wr(3'd0, 32'h0);
    chk("R9 time running", time_now, 64'h8_0000_0110);
    wr(3'd4, 32'h0);
    wr(3'd5, 32'h0);

    // R10 wrap
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    chk("R10 loaded all ones", time_now, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(3'd0, 32'h3);
    wr(3'd0, 32'h0);
    chk("R10 wrap to zero", time_now, 64'h0);
    chk("R11 tick on wrap step", {63'h0, tick}, 64'h1);
    rd(3'd2, 32'h0, "R10 cnt lo");
    rd(3'd3, 32'h0, "R10 cnt hi");
    idle(2);
    chk("R12 all reads returned", 64'(exp_q.size()), 64'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule